// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

The sequencer turns single read or write requests from an on-chip requester into timed cycles on an external memory bus. It captures the request and a per-access configuration in the same cycle. It then runs four phases in order: an address-latch phase with the latch strobe high, an optional idle delay, a strobe phase with the read or write strobe low, and an optional recovery gap. After the recovery gap it accepts the next request.

The per-access configuration selects the bus form. The address and data either share one 16-bit port, or the address uses its own port and data uses a separate port. Data is 8 or 16 bits wide. The number of upper segment address lines is 0, 2, 4 or 8. Each phase length is programmable. The strobe phase can also be held until an external ready line, resynchronised through two flops, reaches a selectable level. When the cycle ends, the requester sees a one-cycle completion pulse. For a read, the captured data is valid in that same cycle.

Top module: `xbus_seq`

## Requirements
- R1: After reset, and whenever no cycle is in progress, `ale` is 0, `rd_n` and `wr_n` are 1, both output enables are 0, `done` is 0 and `req_ready` is 1.
- R2: A request is taken when `req_valid` is 1 while `req_ready` is 1. From the next cycle, `ale` stays high for `cfg_ale_len`+1 cycles. In multiplexed mode (`cfg_mux`=1), `ad_o` carries `req_addr[15:0]` during those cycles, with both `ad_oe_lo` and `ad_oe_hi` set to 1.
- R3: With `cfg_rwdly`=1, exactly one cycle with `ale` low and both strobes high separates the address phase from the strobe phase. With `cfg_rwdly`=0, the strobe falls in the cycle right after `ale` falls. `ale` is never high while a strobe is low.
- R4: With the ready check off (`cfg_rdy_en`=0), the strobe stays low for `cfg_wait`+1 cycles. A read (`req_write`=0) drives only `rd_n` low, and a write drives only `wr_n` low. The two strobes are never low together.
- R5: With `cfg_rdy_en`=1, the strobe phase lasts at least `cfg_wait`+1 cycles, and it ends only after the synchronised `ready_i` equals `cfg_rdy_pol`. Because of the two-flop synchroniser, if `ready_i` becomes active during the strobe's n-th low cycle, the strobe stays low for n+2 cycles, provided that is at least `cfg_wait`+1.
- R6: On a multiplexed read, both output enables are 0 from the end of the address phase to the end of the cycle, so the shared port is released.
- R7: On a write, `ad_o` carries the write data during the delay and strobe phases, with `ad_oe_lo`=1 and `ad_oe_hi` = not `cfg_bus8`. For 8-bit data (`cfg_bus8`=1), only `req_wdata[7:0]` is driven and `ad_o[15:8]` is 0.
- R8: In demultiplexed mode (`cfg_mux`=0), `addr_o` carries `req_addr[15:0]` through the address, delay and strobe phases. In multiplexed mode, `addr_o` is 0.
- R9: During the address, delay and strobe phases, `seg_o` carries `req_addr[23:16]` masked by the width code `cfg_aw`: 0 gives no lines, 1 gives bits [1:0], 2 gives bits [3:0] and 3 gives all 8 lines. Masked lines are 0.
- R10: `done` is high for exactly one cycle, the cycle right after the last strobe-low cycle. In that cycle, a read has `rdata` equal to `ad_i` as sampled in the last strobe cycle; with 8-bit data this is `{8'h00, ad_i[7:0]}`.
- R11: `req_ready` returns to 1 `cfg_rec`×1 cycles after the `done` cycle, so with `cfg_rec`=0 it is already 1 in the `done` cycle. `ale` never rises unless `req_ready` was 1 in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| cfg_mux | input | 1 | 1 = shared address/data port |
| cfg_bus8 | input | 1 | 1 = 8-bit data |
| cfg_aw | input | 2 | Segment width code (0/1/2/3 → 0/2/4/8 lines) |
| cfg_ale_len | input | 2 | Address phase length minus one |
| cfg_wait | input | 4 | Minimum strobe length minus one |
| cfg_rwdly | input | 1 | Insert one delay cycle before the strobe |
| cfg_rec | input | 2 | Recovery cycles after the strobe |
| cfg_rdy_en | input | 1 | Hold the strobe until ready is active |
| cfg_rdy_pol | input | 1 | Active level of ready |
| req_ready | output | 1 | Idle, a request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_o | output | 16 | Dedicated address port |
| seg_o | output | 8 | Upper segment address lines |
| ad_o | output | 16 | Data or shared address/data output |
| ad_oe_lo | output | 1 | Output enable, low byte |
| ad_oe_hi | output | 1 | Output enable, high byte |
| ad_i | input | 16 | Data input from the bus |
| ready_i | input | 1 | Asynchronous external ready |

## Verification
The assertions check a set of rules on every cycle:
- the two strobes are never low together;
- the latch strobe never overlaps a data strobe;
- the shared port is released while a multiplexed read strobe is low;
- masked segment lines stay 0;
- the high byte is not driven on an 8-bit write;
- `done` is a one-cycle pulse outside any strobe;
- a new address phase starts only from idle.

Only the bench scenarios can show that each phase has the programmed length, including the exact two-flop stretch when ready is released mid-strobe. The same applies to the address and data values placed on each port and to the captured read data.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int LOW_W  = 16;
    localparam int SEG_W  = ADDR_W - LOW_W;
    localparam int ALE_W  = 2;
    localparam int WAIT_W = 4;
    localparam int REC_W  = 2;
    localparam int CNT_W  = WAIT_W;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_DLY, ST_STRB, ST_RECOV
    } xb_state_e;

    typedef enum logic [1:0] {AW_16 = 2'd0, AW_18 = 2'd1, AW_20 = 2'd2, AW_24 = 2'd3} xb_aw_e;

    typedef struct packed {
        logic              mux;
        logic              bus8;
        xb_aw_e            aw;
        logic [ALE_W-1:0]  ale_len;
        logic [WAIT_W-1:0] waits;
        logic              rwdly;
        logic [REC_W-1:0]  rec_len;
        logic              rdy_en;
        logic              rdy_pol;
    } xb_cfg_t;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xb_req_t;

    function automatic logic [SEG_W-1:0] seg_mask(xb_aw_e aw);
        int n;
        case (aw)
            AW_16:   n = 0;
            AW_18:   n = 2;
            AW_20:   n = 4;
            default: n = SEG_W;
        endcase
        for (int i = 0; i < SEG_W; i++) seg_mask[i] = (i < n);
    endfunction

    function automatic logic [DATA_W-1:0] narrow(logic [DATA_W-1:0] v, logic bus8);
        return bus8 ? {{(DATA_W-8){1'b0}}, v[7:0]} : v;
    endfunction
endpackage

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d_i};
    end
    assign q_o = sh[STAGES-1];
endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  xb_cfg_t   cfg_in,
    input  logic      rdy_s,
    output xb_state_e state,
    output xb_cfg_t   cfg_q,
    output logic      last_strb
);
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;
    logic             rdy_ok;

    assign cnt_zero  = (cnt == '0);
    assign rdy_ok    = !cfg_q.rdy_en || (rdy_s == cfg_q.rdy_pol);
    assign last_strb = (state == ST_STRB) && cnt_zero && rdy_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cfg_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_ADDR;
                    cfg_q <= cfg_in;
                    cnt   <= CNT_W'(cfg_in.ale_len);
                end
                ST_ADDR: begin
                    if (cnt_zero) begin
                        if (cfg_q.rwdly) state <= ST_DLY;
                        else begin
                            state <= ST_STRB;
                            cnt   <= CNT_W'(cfg_q.waits);
                        end
                    end else cnt <= cnt - 1'b1;
                end
                ST_DLY: begin
                    state <= ST_STRB;
                    cnt   <= CNT_W'(cfg_q.waits);
                end
                ST_STRB: begin
                    if (!cnt_zero) cnt <= cnt - 1'b1;
                    else if (rdy_ok) begin
                        if (cfg_q.rec_len == '0) state <= ST_IDLE;
                        else begin
                            state <= ST_RECOV;
                            cnt   <= CNT_W'(cfg_q.rec_len - 1'b1);
                        end
                    end
                end
                ST_RECOV: begin
                    if (cnt_zero) state <= ST_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xbus_pinmux.sv
module xbus_pinmux
    import xbus_pkg::*;
(
    input  xb_state_e         state,
    input  xb_cfg_t           cfg_q,
    input  xb_req_t           req_q,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [LOW_W-1:0]  addr_o,
    output logic [SEG_W-1:0]  seg_o,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe_lo,
    output logic              ad_oe_hi
);
    logic bus_act, in_strb, data_ph;

    assign bus_act = (state == ST_ADDR) || (state == ST_DLY) || (state == ST_STRB);
    assign in_strb = (state == ST_STRB);
    assign data_ph = (state == ST_DLY) || in_strb;

    assign ale    = (state == ST_ADDR);
    assign rd_n   = !(in_strb && !req_q.write);
    assign wr_n   = !(in_strb && req_q.write);
    assign addr_o = (bus_act && !cfg_q.mux) ? req_q.addr[LOW_W-1:0] : '0;
    assign seg_o  = bus_act ? (req_q.addr[ADDR_W-1:LOW_W] & seg_mask(cfg_q.aw)) : '0;

    always_comb begin
        ad_o     = '0;
        ad_oe_lo = 1'b0;
        ad_oe_hi = 1'b0;
        if (ale && cfg_q.mux) begin
            ad_o     = req_q.addr[LOW_W-1:0];
            ad_oe_lo = 1'b1;
            ad_oe_hi = 1'b1;
        end else if (data_ph && req_q.write) begin
            ad_o     = narrow(req_q.wdata, cfg_q.bus8);
            ad_oe_lo = 1'b1;
            ad_oe_hi = !cfg_q.bus8;
        end
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_mux,
    input  logic              cfg_bus8,
    input  logic [1:0]        cfg_aw,
    input  logic [ALE_W-1:0]  cfg_ale_len,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_rwdly,
    input  logic [REC_W-1:0]  cfg_rec,
    input  logic              cfg_rdy_en,
    input  logic              cfg_rdy_pol,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [LOW_W-1:0]  addr_o,
    output logic [SEG_W-1:0]  seg_o,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe_lo,
    output logic              ad_oe_hi,
    input  logic [DATA_W-1:0] ad_i,
    input  logic              ready_i
);
    xb_state_e state;
    xb_cfg_t   cfg_in, cfg_q;
    xb_req_t   req_q;
    logic      start, rdy_s, last_strb;

    assign cfg_in = '{mux: cfg_mux, bus8: cfg_bus8, aw: xb_aw_e'(cfg_aw),
                      ale_len: cfg_ale_len, waits: cfg_wait, rwdly: cfg_rwdly,
                      rec_len: cfg_rec, rdy_en: cfg_rdy_en, rdy_pol: cfg_rdy_pol};
    assign req_ready = (state == ST_IDLE);
    assign start     = req_valid && req_ready;

    xbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_i(ready_i), .q_o(rdy_s)
    );

    xbus_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .cfg_in(cfg_in), .rdy_s(rdy_s),
        .state(state), .cfg_q(cfg_q), .last_strb(last_strb)
    );

    xbus_pinmux u_pins (
        .state(state), .cfg_q(cfg_q), .req_q(req_q),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .addr_o(addr_o), .seg_o(seg_o),
        .ad_o(ad_o), .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            if (start) req_q <= '{write: req_write, addr: req_addr, wdata: req_wdata};
            done <= last_strb;
            if (last_strb && !req_q.write) rdata <= narrow(ad_i, cfg_q.bus8);
        end
    end
endmodule

// File: rtl/xbus_chk.sv
module xbus_chk
    import xbus_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ale,
    input logic             rd_n,
    input logic             wr_n,
    input logic             ad_oe_lo,
    input logic             ad_oe_hi,
    input logic [SEG_W-1:0] seg_o,
    input logic             req_ready,
    input logic             done,
    input xb_cfg_t          cfg_q
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!ale && rd_n && wr_n && !ad_oe_lo && !ad_oe_hi));
    assert_ale_apart_R3: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n));
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));
    assert_mux_read_released_R6: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && cfg_q.mux) |-> (!ad_oe_lo && !ad_oe_hi));
    assert_byte_write_hi_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && cfg_q.bus8) |-> !ad_oe_hi);
    assert_seg_masked_R9: assert property (@(posedge clk) disable iff (rst)
        (seg_o & ~seg_mask(cfg_q.aw)) == '0);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (rd_n && wr_n && !ale));
    assert_ale_from_idle_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |-> $past(req_ready));
endmodule

bind xbus_seq xbus_chk u_chk (
    .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi), .seg_o(seg_o),
    .req_ready(req_ready), .done(done), .cfg_q(cfg_q)
);

// File: tb/xbus_seq_tb.sv
`timescale 1ns/1ps
module xbus_seq_tb;
    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0;
    logic [23:0] req_addr = 0;
    logic [15:0] req_wdata = 0;
    logic c_mux = 0, c_bus8 = 0, c_dly = 0, c_ren = 0, c_rpol = 0;
    logic [1:0] c_aw = 0, c_ale = 0, c_rec = 0;
    logic [3:0] c_wait = 0;
    logic req_ready, done, ale, rd_n, wr_n, ad_oe_lo, ad_oe_hi;
    logic [15:0] rdata, addr_o, ad_o;
    logic [7:0] seg_o;
    logic [15:0] ad_i = 0;
    logic ready_i = 0;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;

    xbus_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_mux(c_mux), .cfg_bus8(c_bus8),
        .cfg_aw(c_aw), .cfg_ale_len(c_ale), .cfg_wait(c_wait), .cfg_rwdly(c_dly),
        .cfg_rec(c_rec), .cfg_rdy_en(c_ren), .cfg_rdy_pol(c_rpol),
        .req_ready(req_ready), .done(done), .rdata(rdata), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .addr_o(addr_o), .seg_o(seg_o), .ad_o(ad_o),
        .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi), .ad_i(ad_i), .ready_i(ready_i)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_seg(logic [23:0] a, logic [1:0] aw);
        logic [7:0] m;
        m = (aw == 0) ? 8'h00 : (aw == 1) ? 8'h03 : (aw == 2) ? 8'h0F : 8'hFF;
        return a[23:16] & m;
    endfunction

    function automatic logic [15:0] exp_nar(logic [15:0] v, logic b8);
        return b8 ? {8'h00, v[7:0]} : v;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // one transaction; rel > 0 releases ready after rel strobe-low cycles
    task automatic run_txn(input logic wr, input logic [23:0] a, input logic [15:0] wd, input int rel);
        int ale_n = 0, gap_n = 0, strb_n = 0, rec_n = 0, guard = 0;
        bit seen_done = 0, ok2 = 1, ok6 = 1, ok7 = 1, ok8 = 1, ok9 = 1, ok4 = 1;
        int exp_strb;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        ad_i = 16'($urandom);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        forever begin
            guard++;
            if (guard > 200) break;
            if (!seen_done) begin
                if (ale) begin
                    ale_n++;
                    if (c_mux && !(ad_o == a[15:0] && ad_oe_lo && ad_oe_hi)) ok2 = 0;
                    if (!c_mux && addr_o != a[15:0]) ok8 = 0;
                    if (c_mux && addr_o != 0) ok8 = 0;
                    if (seg_o != exp_seg(a, c_aw)) ok9 = 0;
                end else if (!rd_n || !wr_n) begin
                    strb_n++;
                    if (wr ? (rd_n != 1 || wr_n != 0) : (rd_n != 0 || wr_n != 1)) ok4 = 0;
                    if (!c_mux && addr_o != a[15:0]) ok8 = 0;
                    if (seg_o != exp_seg(a, c_aw)) ok9 = 0;
                    if (wr && !(ad_o == exp_nar(wd, c_bus8) && ad_oe_lo && ad_oe_hi == !c_bus8)) ok7 = 0;
                    if (!wr && c_mux && (ad_oe_lo || ad_oe_hi)) ok6 = 0;
                    if (rel > 0 && strb_n == rel) ready_i = c_rpol;
                end else if (!done && ale_n > 0 && strb_n == 0) begin
                    gap_n++;
                    if (wr && !(ad_o == exp_nar(wd, c_bus8) && ad_oe_lo)) ok7 = 0;
                    if (!wr && c_mux && (ad_oe_lo || ad_oe_hi)) ok6 = 0;
                end
            end
            if (done && !seen_done) begin
                seen_done = 1;
                if (!wr) check("R10 read data", rdata, exp_nar(ad_i, c_bus8));
                check("R10 done after strobe", strb_n > 0 && rd_n && wr_n, 1);
            end
            if (seen_done) begin
                if (req_ready) break;
                rec_n++;
            end
            @(negedge clk);
        end
        exp_strb = (rel > 0) ? rel + 2 : c_wait + 1;
        check("R2 ale length", ale_n, c_ale + 1);
        check("R2 mux address phase", ok2, 1);
        check("R3 delay gap", gap_n, c_dly);
        check(c_ren ? "R5 ready strobe length" : "R4 strobe length", strb_n, exp_strb);
        check("R4 strobe select", ok4, 1);
        check("R6 mux read release", ok6, 1);
        check("R7 write data", ok7, 1);
        check("R8 address port", ok8, 1);
        check("R9 segment lines", ok9, 1);
        check("R11 recovery", rec_n, c_rec);
    endtask

    task automatic set_cfg(input logic m, input logic b8, input logic [1:0] aw, input logic [1:0] al,
                           input logic [3:0] w, input logic d, input logic [1:0] rc,
                           input logic ren, input logic rp);
        c_mux = m; c_bus8 = b8; c_aw = aw; c_ale = al; c_wait = w; c_dly = d;
        c_rec = rc; c_ren = ren; c_rpol = rp;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset idle", {ale, rd_n, wr_n, ad_oe_lo, ad_oe_hi, done, req_ready}, 7'b0110001);

        // directed: each mode, edge lengths
        set_cfg(1, 0, 3, 0, 0, 0, 0, 0, 0); run_txn(0, 24'hABCDEF, 16'h0, 0);
        set_cfg(1, 1, 2, 3, 5, 1, 3, 0, 0); run_txn(1, 24'h5A1234, 16'hBEEF, 0);
        set_cfg(0, 0, 1, 1, 2, 1, 1, 0, 0); run_txn(1, 24'hFF8001, 16'h1357, 0);
        set_cfg(0, 1, 0, 2, 15, 0, 2, 0, 0); run_txn(0, 24'h37C0DE, 16'h0, 0);
        // R5: ready released mid strobe, both polarities
        set_cfg(0, 0, 3, 0, 1, 0, 1, 1, 1); ready_i = 0; run_txn(0, 24'h123456, 16'h0, 5);
        set_cfg(1, 0, 2, 1, 2, 1, 0, 1, 0); ready_i = 1; run_txn(1, 24'h0F0F0F, 16'hA5C3, 6);

        // random mix; ready held at active level well ahead
        for (int i = 0; i < 60; i++) begin
            set_cfg($urandom % 2, $urandom % 2, $urandom % 4, $urandom % 4, $urandom % 16,
                    $urandom % 2, $urandom % 4, $urandom % 2, $urandom % 2);
            ready_i = c_rpol;
            run_txn($urandom % 2, 24'($urandom), 16'($urandom), 0);
        end

        @(negedge clk);
        check("R1 idle after traffic", {ale, rd_n, wr_n, ad_oe_lo, ad_oe_hi, done, req_ready}, 7'b0110001);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule